// File: doc/BRIEF.md
# Single-Cycle RV32I Processor Core

This block is a 32-bit RISC-V base-integer core that completes every instruction in one clock period. Fetch, decode, operand read, ALU work, data access and register write-back all settle combinationally between two rising edges. The only state the clock moves is the program counter and the register file. Instruction and data memories sit on separate ports, and both are read asynchronously. The core puts the program counter on the instruction port and gets the instruction word back in the same cycle. It puts the ALU sum on the data port and gets load data back in the same cycle.

The core is meant for a system where both memories answer without wait states. Stores drive a per-byte write mask, so the memory needs no read-modify-write cycle for byte or halfword stores. Load lanes are picked and extended inside the core. Opcodes outside the supported set, such as the fence and system groups, retire as no-ops. The decoder holds no sequencing state: each instruction is decoded from the fetched word alone.

Top module: `rvc_core`

## Requirements
- R1: Register x0 always reads as zero. A write aimed at x0 leaves it zero, and a write to any other register returns the written value on the next read.
- R2: While `rst_n` is low, `imem_addr` is 0x00000000 and `dmem_we` is low. The first instruction executed after release is the one at address 0.
- R3: Every instruction other than a taken branch, JAL or JALR advances the PC by exactly 4 on the next clock edge.
- R4: Register-register and register-immediate ADD, SUB, AND, OR, XOR, SLT, SLTU, SLL, SRL and SRA compute the standard RV32I results. A shift uses only the low 5 bits of its amount.
- R5: LUI writes imm20<<12 into rd. AUIPC writes that value plus the PC of the AUIPC itself.
- R6: BEQ, BNE, BLT, BGE, BLTU and BGEU go to PC+offset when taken and to PC+4 otherwise. Negative offsets branch backward.
- R7: JAL writes PC+4 into rd and jumps to PC plus its sign-extended offset.
- R8: JALR writes PC+4 into rd and jumps to (rs1 + sign-extended imm12) with bit 0 forced to 0.
- R9: The data address of a load or store is rs1 plus its sign-extended 12-bit offset. LW returns the full word.
- R10: LB and LH sign-extend, and LBU and LHU zero-extend. The byte in lane k comes from bits 8k+7..8k with k = addr[1:0]. The halfword comes from bits 15..0 when addr[1] is 0 and from bits 31..16 when it is 1.
- R11: A store raises `dmem_we` for its cycle. SB drives mask 0001<<addr[1:0], SH drives 0011<<addr[1:0], and SW drives 1111. The store data is repeated across all lanes, so only the masked bytes of the word change.
- R12: A load, or any instruction that is not a store, keeps `dmem_we` low.
- R13: An unsupported opcode (for example 0001111 or 1110011) writes no register, performs no store and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one instruction retires per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Instruction fetch address (the PC) |
| imem_rdata | input | 32 | Instruction word returned combinationally |
| dmem_addr | output | 32 | Data address (ALU sum) |
| dmem_wdata | output | 32 | Store data, replicated across lanes |
| dmem_wmask | output | 4 | Byte write enables, bit k for bits 8k+7..8k |
| dmem_we | output | 1 | Store strobe for the current cycle |
| dmem_rdata | input | 32 | Load data returned combinationally |

## Verification
The only state is the PC and the register file, so a wrong PC shows on `imem_addr` at the very next edge. A wrong register value shows only when a later instruction consumes it, which is why each program stores its results to data memory. A bad mask or lane shift corrupts neighbouring bytes of a preset word, and the bench sees this as soon as the store cycle ends. A store that leaks during reset, or an unsupported opcode that writes anything, leaves a sentinel word changed or a store logged that should not be there.

// File: rtl/rvc_pkg.sv
package rvc_pkg;

    typedef enum logic [3:0] {
        ALU_ADD  = 4'd0,
        ALU_SUB  = 4'd1,
        ALU_SLL  = 4'd2,
        ALU_SLT  = 4'd3,
        ALU_SLTU = 4'd4,
        ALU_XOR  = 4'd5,
        ALU_SRL  = 4'd6,
        ALU_SRA  = 4'd7,
        ALU_OR   = 4'd8,
        ALU_AND  = 4'd9
    } alu_op_e;

    typedef enum logic [1:0] {
        WB_ALU  = 2'd0,
        WB_MEM  = 2'd1,
        WB_LINK = 2'd2,
        WB_IMM  = 2'd3
    } wb_sel_e;

    localparam logic [6:0] OPC_LUI    = 7'b0110111;
    localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
    localparam logic [6:0] OPC_JAL    = 7'b1101111;
    localparam logic [6:0] OPC_JALR   = 7'b1100111;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_LOAD   = 7'b0000011;
    localparam logic [6:0] OPC_STORE  = 7'b0100011;
    localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
    localparam logic [6:0] OPC_OP     = 7'b0110011;

    typedef struct packed {
        alu_op_e alu_op;
        logic    a_pc;
        logic    b_imm;
        logic    rd_we;
        wb_sel_e wb_sel;
        logic    load;
        logic    store;
        logic    branch;
        logic    jal;
        logic    jalr;
    } ctrl_t;

endpackage

// File: rtl/rvc_decode.sv
module rvc_decode
    import rvc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [31:0]     instr,
    output ctrl_t           ctrl,
    output logic [XLEN-1:0] imm
);
    logic [6:0] opc;
    logic [2:0] f3;
    logic       alt;
    alu_op_e    arith;

    assign opc = instr[6:0];
    assign f3  = instr[14:12];
    assign alt = instr[30];

    // funct3 to ALU operation; alt selects SUB (register form only) and SRA
    always_comb begin
        unique case (f3)
            3'b000:  arith = (alt && opc == OPC_OP) ? ALU_SUB : ALU_ADD;
            3'b001:  arith = ALU_SLL;
            3'b010:  arith = ALU_SLT;
            3'b011:  arith = ALU_SLTU;
            3'b100:  arith = ALU_XOR;
            3'b101:  arith = alt ? ALU_SRA : ALU_SRL;
            3'b110:  arith = ALU_OR;
            default: arith = ALU_AND;
        endcase
    end

    always_comb begin
        ctrl = '0;
        imm  = '0;
        unique case (opc)
            OPC_LUI: begin
                imm = XLEN'({instr[31:12], 12'b0});
                ctrl.rd_we = 1'b1; ctrl.wb_sel = WB_IMM;
            end
            OPC_AUIPC: begin
                imm = XLEN'({instr[31:12], 12'b0});
                ctrl.rd_we = 1'b1; ctrl.a_pc = 1'b1; ctrl.b_imm = 1'b1;
            end
            OPC_JAL: begin
                imm = {{(XLEN-20){instr[31]}}, instr[19:12], instr[20], instr[30:21], 1'b0};
                ctrl.rd_we = 1'b1; ctrl.wb_sel = WB_LINK; ctrl.jal = 1'b1;
            end
            OPC_JALR: begin
                imm = {{(XLEN-12){instr[31]}}, instr[31:20]};
                ctrl.rd_we = 1'b1; ctrl.wb_sel = WB_LINK; ctrl.b_imm = 1'b1; ctrl.jalr = 1'b1;
            end
            OPC_BRANCH: begin
                imm = {{(XLEN-12){instr[31]}}, instr[7], instr[30:25], instr[11:8], 1'b0};
                ctrl.branch = 1'b1;
            end
            OPC_LOAD: begin
                imm = {{(XLEN-12){instr[31]}}, instr[31:20]};
                ctrl.rd_we = 1'b1; ctrl.wb_sel = WB_MEM; ctrl.b_imm = 1'b1; ctrl.load = 1'b1;
            end
            OPC_STORE: begin
                imm = {{(XLEN-12){instr[31]}}, instr[31:25], instr[11:7]};
                ctrl.b_imm = 1'b1; ctrl.store = 1'b1;
            end
            OPC_OPIMM: begin
                imm = {{(XLEN-12){instr[31]}}, instr[31:20]};
                ctrl.rd_we = 1'b1; ctrl.b_imm = 1'b1; ctrl.alu_op = arith;
            end
            OPC_OP: begin
                ctrl.rd_we = 1'b1; ctrl.alu_op = arith;
            end
            default: ;  // unsupported opcode retires as a no-op (R13)
        endcase
    end

endmodule

// File: rtl/rvc_alu.sv
module rvc_alu
    import rvc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);
    localparam int SHW = $clog2(XLEN);

    logic [SHW-1:0] sh;
    assign sh = b[SHW-1:0];  // R4: low bits of the amount only

    always_comb begin
        unique case (op)
            ALU_ADD:  y = a + b;
            ALU_SUB:  y = a - b;
            ALU_SLL:  y = a << sh;
            ALU_SLT:  y = XLEN'($signed(a) < $signed(b));
            ALU_SLTU: y = XLEN'(a < b);
            ALU_XOR:  y = a ^ b;
            ALU_SRL:  y = a >> sh;
            ALU_SRA:  y = $unsigned($signed(a) >>> sh);
            ALU_OR:   y = a | b;
            ALU_AND:  y = a & b;
            default:  y = '0;
        endcase
    end

endmodule

// File: rtl/rvc_regfile.sv
module rvc_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   raddr_a,
    input  logic [AW-1:0]   raddr_b,
    output logic [XLEN-1:0] rdata_a,
    output logic [XLEN-1:0] rdata_b,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata
);
    logic [XLEN-1:0] regs [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (i == 0) begin : g_zero
            assign regs[i] = '0;  // R1: hard-wired zero
        end else begin : g_store
            always_ff @(posedge clk) begin
                if (we && waddr == AW'(i)) regs[i] <= wdata;
            end
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];

    // R1: a write to a nonzero register is visible on the next cycle
    a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr != '0) |=> regs[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/rvc_core.sv
module rvc_core
    import rvc_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [XLEN-1:0]   imem_addr,
    input  logic [31:0]       imem_rdata,
    output logic [XLEN-1:0]   dmem_addr,
    output logic [XLEN-1:0]   dmem_wdata,
    output logic [XLEN/8-1:0] dmem_wmask,
    output logic              dmem_we,
    input  logic [XLEN-1:0]   dmem_rdata
);
    localparam int NLANES = XLEN / 8;
    localparam int LANE_W = $clog2(NLANES);
    localparam int AW     = $clog2(NREG);

    logic [XLEN-1:0]   pc, pc_next, pc_plus4, pc_rel;
    ctrl_t             ctrl;
    logic [XLEN-1:0]   imm, rs1v, rs2v, alu_a, alu_b, alu_y;
    logic [XLEN-1:0]   load_val, wb_val, lane_data;
    logic [2:0]        f3;
    logic [LANE_W-1:0] byte_off;
    logic              take;

    assign f3 = imem_rdata[14:12];

    rvc_decode #(.XLEN(XLEN)) u_dec (.instr(imem_rdata), .ctrl(ctrl), .imm(imm));

    rvc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .raddr_a(imem_rdata[15 +: AW]), .raddr_b(imem_rdata[20 +: AW]),
        .rdata_a(rs1v), .rdata_b(rs2v),
        .we(ctrl.rd_we & rst_n), .waddr(imem_rdata[7 +: AW]), .wdata(wb_val)
    );

    assign alu_a = ctrl.a_pc  ? pc  : rs1v;
    assign alu_b = ctrl.b_imm ? imm : rs2v;

    rvc_alu #(.XLEN(XLEN)) u_alu (.op(ctrl.alu_op), .a(alu_a), .b(alu_b), .y(alu_y));

    // branch condition
    always_comb begin
        unique case (f3)
            3'b000:  take = (rs1v == rs2v);
            3'b001:  take = (rs1v != rs2v);
            3'b100:  take = ($signed(rs1v) <  $signed(rs2v));
            3'b101:  take = ($signed(rs1v) >= $signed(rs2v));
            3'b110:  take = (rs1v <  rs2v);
            3'b111:  take = (rs1v >= rs2v);
            default: take = 1'b0;
        endcase
    end

    // next PC
    assign pc_plus4 = pc + XLEN'(4);
    assign pc_rel   = pc + imm;
    always_comb begin
        if (ctrl.jalr)                          pc_next = {alu_y[XLEN-1:1], 1'b0};
        else if (ctrl.jal || (ctrl.branch && take)) pc_next = pc_rel;
        else                                    pc_next = pc_plus4;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc <= '0;
        else        pc <= pc_next;
    end

    assign imem_addr = pc;
    assign dmem_addr = alu_y;
    assign byte_off  = alu_y[LANE_W-1:0];

    // load lane extraction and extension
    assign lane_data = dmem_rdata >> {byte_off, 3'b000};
    always_comb begin
        unique case (f3)
            3'b000:  load_val = {{(XLEN-8){lane_data[7]}},   lane_data[7:0]};
            3'b001:  load_val = {{(XLEN-16){lane_data[15]}}, lane_data[15:0]};
            3'b100:  load_val = {{(XLEN-8){1'b0}},           lane_data[7:0]};
            3'b101:  load_val = {{(XLEN-16){1'b0}},          lane_data[15:0]};
            default: load_val = dmem_rdata;
        endcase
    end

    // store mask and replicated data
    always_comb begin
        unique case (f3[1:0])
            2'b00: begin
                dmem_wmask = NLANES'(1) << byte_off;
                dmem_wdata = {NLANES{rs2v[7:0]}};
            end
            2'b01: begin
                dmem_wmask = NLANES'(3) << byte_off;
                dmem_wdata = {(NLANES/2){rs2v[15:0]}};
            end
            default: begin
                dmem_wmask = '1;
                dmem_wdata = rs2v;
            end
        endcase
        if (!ctrl.store) dmem_wmask = '0;
    end
    assign dmem_we = ctrl.store & rst_n;

    // write-back select
    always_comb begin
        unique case (ctrl.wb_sel)
            WB_MEM:  wb_val = load_val;
            WB_LINK: wb_val = pc_plus4;
            WB_IMM:  wb_val = imm;
            default: wb_val = alu_y;
        endcase
    end

    // R2: PC held at zero through reset
    a_r2_pc_reset: assert property (@(posedge clk)
        !rst_n |=> imem_addr == '0);

    // R3: non-control opcodes step the PC by 4
    a_r3_seq_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_rdata[6:0] != OPC_JAL && imem_rdata[6:0] != OPC_JALR && imem_rdata[6:0] != OPC_BRANCH)
        |=> imem_addr == $past(imem_addr) + XLEN'(4));

    // R8: JALR target has bit 0 cleared
    a_r8_jalr_even: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_rdata[6:0] == OPC_JALR) |=> !imem_addr[0]);

    // R11: a byte store enables exactly one lane
    a_r11_sb_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (dmem_we && imem_rdata[14:12] == 3'b000) |-> $countones(dmem_wmask) == 1);

    // R12: loads never strobe a write
    a_r12_load_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_rdata[6:0] == OPC_LOAD) |-> !dmem_we);

endmodule

// File: tb/rvc_core_tb.sv
`timescale 1ns/1ps
module rvc_core_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic [3:0]  dmem_wmask;
    logic        dmem_we;

    logic [31:0] imem [64];
    logic [31:0] dmem [64];
    logic [3:0]  mlog [16];
    int          mcnt;
    int          ptr;
    int          checks = 0;
    int          fails  = 0;

    always #2 clk = ~clk;  // 250 MHz

    rvc_core u_dut (
        .clk(clk), .rst_n(rst_n),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .dmem_wmask(dmem_wmask), .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
    );

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) begin
        if (dmem_we) begin
            for (int k = 0; k < 4; k++)
                if (dmem_wmask[k]) dmem[dmem_addr[7:2]][8*k +: 8] <= dmem_wdata[8*k +: 8];
            if (mcnt < 16) mlog[mcnt] <= dmem_wmask;
            mcnt <= mcnt + 1;
        end
    end

    // ---------------- encoders ----------------
    function automatic logic [31:0] e_r(int f7, int f3, int rd, int rs1, int rs2);
        return {7'(f7), 5'(rs2), 5'(rs1), 3'(f3), 5'(rd), 7'b0110011};
    endfunction
    function automatic logic [31:0] e_i(int f3, int rd, int rs1, int imm);
        logic [31:0] v = imm;
        return {v[11:0], 5'(rs1), 3'(f3), 5'(rd), 7'b0010011};
    endfunction
    function automatic logic [31:0] e_ld(int f3, int rd, int rs1, int imm);
        logic [31:0] v = imm;
        return {v[11:0], 5'(rs1), 3'(f3), 5'(rd), 7'b0000011};
    endfunction
    function automatic logic [31:0] e_st(int f3, int rs2, int rs1, int imm);
        logic [31:0] v = imm;
        return {v[11:5], 5'(rs2), 5'(rs1), 3'(f3), v[4:0], 7'b0100011};
    endfunction
    function automatic logic [31:0] e_br(int f3, int rs1, int rs2, int imm);
        logic [31:0] v = imm;
        return {v[12], v[10:5], 5'(rs2), 5'(rs1), 3'(f3), v[4:1], v[11], 7'b1100011};
    endfunction
    function automatic logic [31:0] e_u(int rd, int imm20, logic [6:0] op);
        logic [31:0] v = imm20;
        return {v[19:0], 5'(rd), op};
    endfunction
    function automatic logic [31:0] e_jal(int rd, int imm);
        logic [31:0] v = imm;
        return {v[20], v[10:1], v[11], v[19:12], 5'(rd), 7'b1101111};
    endfunction
    function automatic logic [31:0] e_jalr(int rd, int rs1, int imm);
        logic [31:0] v = imm;
        return {v[11:0], 5'(rs1), 3'b000, 5'(rd), 7'b1100111};
    endfunction

    // ---------------- helpers ----------------
    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 64; i++) imem[i] = 32'h0000006F;  // jal x0,0
        ptr = 0;
    endtask

    task automatic emit(logic [31:0] w);
        imem[ptr] = w;
        ptr++;
    endtask

    task automatic save(int rg, int slot);
        emit(e_st(2, rg, 0, 128 + 4*slot));
    endtask

    task automatic run(int n);
        rst_n = 1'b0;
        mcnt  = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        clear_prog();
        emit(e_st(2, 0, 0, 128));  // sw x0,128(x0)
        dmem[32] = 32'h5A5A5A5A;
        rst_n = 1'b0;
        mcnt  = 0;
        repeat (3) @(negedge clk);
        chk("R2 pc in reset", imem_addr, 32'h0);
        chk("R2 no store in reset", {31'b0, dmem_we}, 32'h0);
        chk("R2 memory untouched in reset", dmem[32], 32'h5A5A5A5A);
        rst_n = 1'b1;
        #1;
        chk("R2 first fetch at 0", imem_addr, 32'h0);
        @(negedge clk);
        chk("R3 pc steps by 4", imem_addr, 32'h4);
        chk("R2 first instruction executed", dmem[32], 32'h0);
    endtask

    task automatic t_alu();
        clear_prog();
        emit(e_i(0, 1, 0, -7));
        emit(e_i(0, 2, 0, 3));
        emit(e_r(0, 0, 3, 1, 2));       // add
        emit(e_r(32, 0, 4, 2, 1));      // sub
        emit(e_r(0, 7, 5, 1, 2));       // and
        emit(e_r(0, 6, 6, 1, 2));       // or
        emit(e_r(0, 4, 7, 1, 2));       // xor
        emit(e_r(0, 2, 8, 1, 2));       // slt
        emit(e_r(0, 3, 9, 1, 2));       // sltu
        emit(e_r(0, 1, 10, 2, 2));      // sll
        emit(e_r(0, 5, 11, 1, 2));      // srl
        emit(e_r(32, 5, 12, 1, 2));     // sra
        emit(e_i(5, 13, 1, 32'h401));   // srai 1
        emit(e_i(0, 14, 0, 35));
        emit(e_r(0, 1, 14, 2, 14));     // sll by 35 -> by 3
        emit(e_i(0, 0, 0, 5));          // write to x0
        for (int r = 3; r <= 14; r++) save(r, r - 3);
        save(0, 12);
        run(ptr + 4);
        chk("R4 add",  dmem[32], 32'hFFFFFFFC);
        chk("R4 sub",  dmem[33], 32'h0000000A);
        chk("R4 and",  dmem[34], 32'h00000001);
        chk("R4 or",   dmem[35], 32'hFFFFFFFB);
        chk("R4 xor",  dmem[36], 32'hFFFFFFFA);
        chk("R4 slt",  dmem[37], 32'h00000001);
        chk("R4 sltu", dmem[38], 32'h00000000);
        chk("R4 sll",  dmem[39], 32'h00000018);
        chk("R4 srl",  dmem[40], 32'h1FFFFFFF);
        chk("R4 sra",  dmem[41], 32'hFFFFFFFF);
        chk("R4 srai", dmem[42], 32'hFFFFFFFC);
        chk("R4 shift amount low bits", dmem[43], 32'h00000018);
        chk("R1 x0 stays zero", dmem[44], 32'h0);
    endtask

    task automatic t_upper();
        clear_prog();
        emit(e_u(1, 32'h12345, 7'b0110111));
        emit(e_i(0, 1, 1, 32'h678));
        emit(e_u(2, 1, 7'b0010111));    // auipc at pc 8
        emit(e_u(3, 32'hFFFFF, 7'b0110111));
        save(1, 0); save(2, 1); save(3, 2);
        run(ptr + 4);
        chk("R5 lui+addi", dmem[32], 32'h12345678);
        chk("R5 auipc", dmem[33], 32'h00001008);
        chk("R5 lui high", dmem[34], 32'hFFFFF000);
        chk("R1 register write returned", dmem[32], 32'h12345678);
    endtask

    task automatic t_branch();
        clear_prog();
        emit(e_i(0, 1, 0, -1));
        emit(e_i(0, 2, 0, 1));
        emit(e_i(0, 10, 0, 0));
        emit(e_i(0, 12, 0, 0));
        emit(e_br(0, 1, 1, 8)); emit(e_i(0, 10, 10, 1));   // beq taken
        emit(e_br(1, 1, 1, 8)); emit(e_i(0, 10, 10, 2));   // bne not
        emit(e_br(4, 1, 2, 8)); emit(e_i(0, 10, 10, 4));   // blt taken
        emit(e_br(5, 1, 2, 8)); emit(e_i(0, 10, 10, 8));   // bge not
        emit(e_br(6, 1, 2, 8)); emit(e_i(0, 10, 10, 16));  // bltu not
        emit(e_br(7, 1, 2, 8)); emit(e_i(0, 10, 10, 32));  // bgeu taken
        emit(e_i(0, 11, 0, 3));
        emit(e_i(0, 12, 12, 5));
        emit(e_i(0, 11, 11, -1));
        emit(e_br(1, 11, 0, -8));                          // backward loop
        save(10, 0); save(12, 1);
        run(ptr + 12);
        chk("R6 branch conditions", dmem[32], 32'd26);
        chk("R6 backward branch loop", dmem[33], 32'd15);
    endtask

    task automatic t_jump();
        clear_prog();
        emit(e_i(0, 5, 0, 1));          // 0
        emit(e_jal(1, 12));             // 1 -> 4
        emit(e_i(0, 5, 0, 99));         // 2
        emit(e_i(0, 5, 0, 98));         // 3
        emit(e_i(0, 7, 0, 41));         // 4
        emit(e_jalr(2, 7, 0));          // 5 -> 40
        for (int i = 0; i < 4; i++) emit(e_i(0, 5, 0, 97));
        save(1, 0); save(2, 1); save(5, 2);
        run(ptr + 4);
        chk("R7 jal link", dmem[32], 32'd8);
        chk("R8 jalr link", dmem[33], 32'd24);
        chk("R7 R8 skipped code not run", dmem[34], 32'd1);
        chk("R7 jal offset zero holds pc", imem_addr, 32'd52);
    endtask

    task automatic t_load();
        clear_prog();
        dmem[0] = 32'h80F17F85;
        emit(e_i(0, 20, 0, 8));
        emit(e_ld(0, 1, 0, 0));
        emit(e_ld(4, 2, 0, 0));
        emit(e_ld(0, 3, 0, 1));
        emit(e_ld(0, 4, 0, 3));
        emit(e_ld(4, 5, 0, 2));
        emit(e_ld(1, 6, 0, 0));
        emit(e_ld(1, 7, 0, 2));
        emit(e_ld(5, 8, 0, 2));
        emit(e_ld(2, 9, 20, -8));
        for (int r = 1; r <= 9; r++) save(r, r - 1);
        run(ptr + 4);
        chk("R10 lb lane0 sign", dmem[32], 32'hFFFFFF85);
        chk("R10 lbu lane0", dmem[33], 32'h00000085);
        chk("R10 lb lane1", dmem[34], 32'h0000007F);
        chk("R10 lb lane3 sign", dmem[35], 32'hFFFFFF80);
        chk("R10 lbu lane2", dmem[36], 32'h000000F1);
        chk("R10 lh low", dmem[37], 32'h00007F85);
        chk("R10 lh high sign", dmem[38], 32'hFFFF80F1);
        chk("R10 lhu high", dmem[39], 32'h000080F1);
        chk("R9 lw base+negative offset", dmem[40], 32'h80F17F85);
    endtask

    task automatic t_store();
        clear_prog();
        for (int i = 8; i <= 12; i++) dmem[i] = 32'hFFFFFFFF;
        emit(e_u(1, 32'hA1B2C, 7'b0110111));
        emit(e_i(0, 1, 1, 32'h3D4));
        emit(e_st(0, 1, 0, 33));
        emit(e_st(0, 1, 0, 39));
        emit(e_st(1, 1, 0, 40));
        emit(e_st(1, 1, 0, 46));
        emit(e_st(2, 1, 0, 48));
        run(ptr + 4);
        chk("R11 sb lane1", dmem[8],  32'hFFFFD4FF);
        chk("R11 sb lane3", dmem[9],  32'hD4FFFFFF);
        chk("R11 sh low",   dmem[10], 32'hFFFFC3D4);
        chk("R11 sh high",  dmem[11], 32'hC3D4FFFF);
        chk("R11 sw",       dmem[12], 32'hA1B2C3D4);
        chk("R11 store count", mcnt, 5);
        chk("R11 mask sb1", {28'b0, mlog[0]}, 32'h2);
        chk("R11 mask sb3", {28'b0, mlog[1]}, 32'h8);
        chk("R11 mask sh0", {28'b0, mlog[2]}, 32'h3);
        chk("R11 mask sh2", {28'b0, mlog[3]}, 32'hC);
        chk("R11 mask sw",  {28'b0, mlog[4]}, 32'hF);
    endtask

    task automatic t_noop();
        clear_prog();
        dmem[40] = 32'hC0DEC0DE;
        dmem[0]  = 32'h11223344;
        emit(e_i(0, 3, 0, 5));
        emit(32'h0000000F);             // fence group
        emit(32'h000001F3);             // system group, rd field = x3
        emit(e_i(0, 4, 3, 1));
        emit(e_ld(2, 6, 0, 0));         // load: no strobe
        save(3, 0); save(4, 1);
        run(ptr + 4);
        chk("R13 no register write", dmem[32], 32'd5);
        chk("R13 execution continues", dmem[33], 32'd6);
        chk("R12 R13 only real stores strobe", mcnt, 2);
        chk("R12 sentinel untouched", dmem[40], 32'hC0DEC0DE);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) dmem[i] = 32'h0;
        mcnt = 0;
        t_reset();
        t_alu();
        t_upper();
        t_branch();
        t_jump();
        t_load();
        t_store();
        t_noop();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule